// File: doc/BRIEF.md
# Decade Counter with Seven-Segment Drive

This block is one digit of a decimal counter. A four-bit count runs 0 through 9 on rising clock edges and is decoded straight into seven active-high segment lines for a common-cathode display. A synchronous clear input returns the count to zero, and a hold input freezes it so that clock edges have no effect.

A display-enable input blanks all seven segments at once. Blanking only touches the outputs, so the digit keeps counting while it is dark. A registered copy of display-enable leaves the block one clock later, so a row of digits can pass one blanking signal along. A carry output is high for the lower half of the decade and low for the upper half. Its rising edge marks the wrap from 9 to 0, which lets it clock the next digit. A separate flag drops low only while the count is two.

Top module: `dseg_digit`

## Requirements
- R1: On a rising clock edge with `rst_n` high, `clr` low and `hold` low, the count rises by one.
- R2: A rising clock edge at count 9 with `clr` and `hold` low takes the count to 0.
- R3: A rising edge with `clr` high sets the count to 0, even when `hold` is also high.
- R4: A rising edge with `hold` high and `clr` low leaves the count unchanged.
- R5: `seg` bit 0 is segment a and bit 6 is segment g. With `disp_en` high, `seg` shows the count as follows: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R6: While `disp_en` is low, `seg` is 0 in that same cycle. The count keeps changing as R1 to R4 say.
- R7: After each rising edge with `rst_n` high, `en_out` equals the value `disp_en` had at that edge.
- R8: `carry` is high for counts 0 to 4 and low for counts 5 to 9, whether or not the display is blanked.
- R9: `not_two` is low while the count is 2 and high for every other count, whether or not the display is blanked.
- R10: A rising edge with `rst_n` low sets the count to 0 and `en_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous active-high count clear |
| hold | input | 1 | High: clock edges are ignored and the count is held |
| disp_en | input | 1 | Low: all segments are driven low |
| en_out | output | 1 | `disp_en` delayed by one clock, for chaining |
| seg | output | 7 | Segment drive; bit 0 = a … bit 6 = g, active high |
| carry | output | 1 | High for counts 0–4, low for counts 5–9 |
| not_two | output | 1 | Low only while the count is 2 |

## Verification
Two pairs of functions can fall in the same cycle. In the first, clear and hold are asserted together, and clear has to win. In the second, blanking is applied while the count moves or sits at 2. Here the segments must read zero while `carry` and `not_two` still follow the hidden count, and the count must come out correct once blanking lifts. A vector table drives a clear on the same edge as a hold, holds at count 2 with the display dark, counts through two blank cycles, and clears at 8 so that a clear cannot be mistaken for a natural wrap. Each expected count comes from a bench model of R1 to R4, and every output is compared after each edge.

// File: rtl/dseg_pkg.sv
// Package dseg_pkg
// Shared widths and the digit-to-segment mapping for the decade digit.
// Assumes a decimal digit (0..9); anything above maps to all segments off.
package dseg_pkg;
    localparam int DIGIT_MAX = 9;
    localparam int CW        = $clog2(DIGIT_MAX + 1);
    localparam int SEG_N     = 7;

    typedef logic [CW-1:0]    digit_t;
    typedef logic [SEG_N-1:0] seg_t;

    // Segment pattern for a digit; bit 0 = a ... bit 6 = g, active high.
    function automatic seg_t seg_of(input digit_t d);
        case (d)
            digit_t'(0): seg_of = 7'h3F;
            digit_t'(1): seg_of = 7'h06;
            digit_t'(2): seg_of = 7'h5B;
            digit_t'(3): seg_of = 7'h4F;
            digit_t'(4): seg_of = 7'h66;
            digit_t'(5): seg_of = 7'h6D;
            digit_t'(6): seg_of = 7'h7D;
            digit_t'(7): seg_of = 7'h07;
            digit_t'(8): seg_of = 7'h7F;
            digit_t'(9): seg_of = 7'h6F;
            default:     seg_of = '0;
        endcase
    endfunction
endpackage

// File: rtl/dseg_counter.sv
// Module dseg_counter
// Wrapping counter 0..LAST with synchronous clear and hold.
// Assumes: rst_n is synchronous active-low; clear has priority over hold.
module dseg_counter
    import dseg_pkg::*;
#(
    parameter int LAST = DIGIT_MAX
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  logic   hold,
    output digit_t count
);
    localparam digit_t LAST_V = digit_t'(LAST);

    // Count register: reset, clear, hold or advance with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)              count <= '0;
        else if (clr)            count <= '0;
        else if (hold)           count <= count;
        else if (count == LAST_V) count <= '0;
        else                     count <= count + digit_t'(1);
    end

    p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !hold && count != LAST_V) |=> count == $past(count) + digit_t'(1));
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !hold && count == LAST_V) |=> count == '0);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> $stable(count));
endmodule

// File: rtl/dseg_decoder.sv
// Module dseg_decoder
// Turns the count into segment drive and gates every segment with the
// display enable. Purely combinational; the count itself is untouched.
module dseg_decoder
    import dseg_pkg::*;
(
    input  digit_t count,
    input  logic   disp_en,
    output seg_t   seg
);
    seg_t raw;

    // Lookup of the unblanked pattern.
    always_comb raw = seg_of(count);

    // Per-segment blanking gate.
    for (genvar i = 0; i < SEG_N; i++) begin : g_blank
        assign seg[i] = raw[i] & disp_en;
    end
endmodule

// File: rtl/dseg_flags.sv
// Module dseg_flags
// Chaining outputs: registered enable copy, half-decade carry, not-two flag.
// Assumes rst_n is synchronous active-low.
module dseg_flags
    import dseg_pkg::*;
#(
    parameter int SPLIT = 5,
    parameter int FLAG_VAL = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   disp_en,
    input  digit_t count,
    output logic   en_out,
    output logic   carry,
    output logic   not_two
);
    // One-clock registered copy of the display enable.
    always_ff @(posedge clk) begin
        if (!rst_n) en_out <= 1'b0;
        else        en_out <= disp_en;
    end

    // Decoded flags from the live count.
    always_comb begin
        carry   = (count < digit_t'(SPLIT));
        not_two = (count != digit_t'(FLAG_VAL));
    end
endmodule

// File: rtl/dseg_digit.sv
// Module dseg_digit (top)
// One decade digit: counter, segment decoder and chaining flags.
// Assumes synchronous active-low rst_n and an active-high clr.
module dseg_digit
    import dseg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       hold,
    input  logic       disp_en,
    output logic       en_out,
    output logic [6:0] seg,
    output logic       carry,
    output logic       not_two
);
    digit_t count;

    dseg_counter #(.LAST(DIGIT_MAX)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .hold(hold), .count(count)
    );

    dseg_decoder u_dec (
        .count(count), .disp_en(disp_en), .seg(seg)
    );

    dseg_flags u_flg (
        .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .count(count),
        .en_out(en_out), .carry(carry), .not_two(not_two)
    );

    p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> seg == '0);
    p_eo_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> en_out == $past(disp_en));
    p_carry_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carry) |-> not_two);
    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (!en_out && carry && not_two));
endmodule

// File: tb/dseg_digit_tb.sv
module dseg_digit_tb;
    logic clk = 1'b0;
    logic rst_n, clr, hold, disp_en;
    logic en_out, carry, not_two;
    logic [6:0] seg;
    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dseg_digit u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .hold(hold), .disp_en(disp_en),
        .en_out(en_out), .seg(seg), .carry(carry), .not_two(not_two)
    );

    // Entry: {clr, hold, disp_en, expected count after the edge}
    localparam int NV = 28;
    localparam logic [6:0] VEC [NV] = '{
        7'b001_0001, 7'b001_0010, 7'b001_0011, 7'b001_0100, 7'b001_0101,
        7'b001_0110, 7'b001_0111, 7'b001_1000, 7'b001_1001, 7'b001_0000,
        7'b001_0001, 7'b001_0010, 7'b011_0010, 7'b010_0010, 7'b000_0011,
        7'b000_0100, 7'b001_0101, 7'b111_0000, 7'b001_0001, 7'b001_0010,
        7'b001_0011, 7'b001_0100, 7'b001_0101, 7'b001_0110, 7'b001_0111,
        7'b001_1000, 7'b101_0000, 7'b001_0001
    };

    // Segment pattern as given in R5.
    function automatic logic [6:0] pat(input int d);
        case (d)
            0: pat = 7'h3F; 1: pat = 7'h06; 2: pat = 7'h5B; 3: pat = 7'h4F;
            4: pat = 7'h66; 5: pat = 7'h6D; 6: pat = 7'h7D; 7: pat = 7'h07;
            8: pat = 7'h7F; 9: pat = 7'h6F; default: pat = 7'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input int cnt, input logic en, input logic eo);
        chk({tag, " R5/R6 seg"}, {1'b0, seg}, {1'b0, en ? pat(cnt) : 7'h00});
        chk({tag, " R8 carry"}, {7'b0, carry}, {7'b0, cnt < 5});
        chk({tag, " R9 not_two"}, {7'b0, not_two}, {7'b0, cnt != 2});
        chk({tag, " R7 en_out"}, {7'b0, en_out}, {7'b0, eo});
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clr = 1'b0; hold = 1'b0; disp_en = 1'b1;
        repeat (2) @(negedge clk);
        chk_all("R10 reset", 0, 1'b1, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 first", 1, 1'b1, 1'b1);
        // Re-enter reset to start the table from a known count of 0.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            {clr, hold, disp_en} = VEC[i][6:4];
            @(negedge clk);
            chk_all($sformatf("R1-vec%0d", i), int'(VEC[i][3:0]), disp_en, disp_en);
        end
        // R7: en_out lags a drop of disp_en; segments blank at once (R6).
        clr = 1'b0; hold = 1'b1; disp_en = 1'b0;
        #1;
        chk("R7 en_out lag", {7'b0, en_out}, 8'd1);
        chk("R6 immediate blank", {1'b0, seg}, 8'd0);
        @(negedge clk);
        chk("R7 en_out after edge", {7'b0, en_out}, 8'd0);
        // R6: count moved while dark; visible once re-enabled.
        hold = 1'b0;
        repeat (3) @(negedge clk);
        disp_en = 1'b1;
        #1;
        chk("R6 count kept while blank", {1'b0, seg}, {1'b0, pat(4)});
        // R10: mid-count reset.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_all("R10 mid reset", 0, 1'b1, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule